// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address into a physical address when a translation cache misses. The virtual address splits into a segment index, a page index and a byte offset. The walker reads one word from the segment table of the requesting privilege mode. It then reads one word from the page table that this word points to. From the page word it builds the physical address and the two page attributes: write-protected and no-cache.

Each privilege mode has its own segment table base, given as a frame number. The walker reaches memory through a single 32-bit port. A transfer on this port completes in the cycle where the memory raises its ready signal. The segment word and the page word have their valid flags at different bit positions. A walk that fails ends with exactly one of three fault classes. A walk that succeeds leaves the page word's used and dirty flags set in memory. At most one extra write per walk does this.

A request is taken only while `busy` is low. The result, or the fault, is presented together with a one-cycle `done` pulse.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to (base << 12) + 4 × segment index. The base is `sup_base` when `req_super` is 1 and `usr_base` otherwise. The segment index is VA bits [VA_W-1 : VA_W-IDX_W].
- R2: When the segment word is valid, the second read goes to (segment word bits 31-12) << 12 + 4 × page index. The page index is VA bits [12+IDX_W-1 : 12].
- R3: A segment word with bit 1 clear ends the walk after that single read. The fault is a table fault, `fault` = 3'b001.
- R4: A page word with bit 0 clear ends the walk with a page fault, `fault` = 3'b010.
- R5: A write walk ends with a protection fault, `fault` = 3'b100, when the page word is valid and bit 2 of the segment word or of the page word is set. A read walk never raises this fault.
- R6: A walk without a fault returns `out_pa` = {page word bits 31-12, VA bits 11-0}. It also returns `out_ro` = segment bit 2 OR page bit 2, `out_ci` = page bit 6, and `fault` = 0.
- R7: A walk without a fault writes the page word back once when the word needs a flag set: bit 3 (used) is clear, or the walk is a write and bit 4 (dirty) is clear. The write goes to the page word's address. It carries the original word with bit 3 set, and also bit 4 set on a write walk. Otherwise, and on any fault, nothing is written.
- R8: `done` is high for exactly one cycle per walk. `fault` is one-hot or zero and is nonzero only with `done`. On a fault, `out_pa`, `out_ro` and `out_ci` are 0.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` hold their values into the next cycle.
- R10: While reset is high and in the first cycle after it, `done`, `fault`, `mem_req` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk; taken when `busy` is low |
| req_va | input | VA_W | Virtual address to translate |
| req_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| req_write | input | 1 | 1 for a write access |
| usr_base | input | PA_W-12 | User segment table frame |
| sup_base | input | PA_W-12 | Supervisor segment table frame |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a write transfer |
| mem_addr | output | PA_W | Byte address of the transfer |
| mem_wdata | output | PA_W | Write data |
| mem_rdata | input | PA_W | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Transfer completes this cycle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| out_pa | output | PA_W | Translated physical address |
| out_ro | output | 1 | Write-protected attribute |
| out_ci | output | 1 | No-cache attribute |
| fault | output | 3 | One-hot fault: bit 0 table, bit 1 page, bit 2 protection |

## Verification
The bench builds the walker with IDX_W = 2, which gives a 16-bit virtual address. Every segment index and page index then takes part in real address arithmetic. For both modes and both access kinds, the bench sweeps all 128 combinations of the seven flag bits that the walker decodes. This covers every fault priority, every write-back case and the attribute merge. The memory model adds a wait of 0 to 2 cycles to each transfer. It records every address read and every word written, so the table addresses and the write-back value are checked at the port.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
  // entry flag positions
  localparam int SEG_VALID_BIT = 1;
  localparam int PG_VALID_BIT  = 0;
  localparam int RO_BIT        = 2;
  localparam int USED_BIT      = 3;
  localparam int DIRTY_BIT     = 4;
  localparam int NOCACHE_BIT   = 6;

  // fault vector layout
  localparam int FLT_W     = 3;
  localparam int FLT_TABLE = 0;
  localparam int FLT_PAGE  = 1;
  localparam int FLT_PROT  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEG  = 2'd1,
    ST_PTE  = 2'd2,
    ST_WB   = 2'd3
  } walk_st_t;
endpackage

// File: rtl/pw_addr_gen.sv
`timescale 1ns/1ps
module pw_addr_gen #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input  logic [PA_W-OFF_W-1:0] frame,
  input  logic [IDX_W-1:0]      idx,
  output logic [PA_W-1:0]       addr
);
  localparam int PAD_W = PA_W - IDX_W - 2;

  logic [PA_W-1:0] word_ofs;

  // 4-byte entries; a table fits in one page, so OR equals add
  assign word_ofs = {{PAD_W{1'b0}}, idx, 2'b00};
  assign addr     = {frame, {OFF_W{1'b0}}} | word_ofs;

  initial begin
    if (IDX_W + 2 > OFF_W) $error("table does not fit in one page");
  end
endmodule

// File: rtl/pw_pte_eval.sv
`timescale 1ns/1ps
module pw_pte_eval
  import pw_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input  logic [PA_W-1:0]       pte,
  input  logic                  seg_ro,
  input  logic                  is_write,
  output logic [FLT_W-1:0]      flt,
  output logic                  need_wb,
  output logic [PA_W-1:0]       wb_val,
  output logic [PA_W-OFF_W-1:0] frame,
  output logic                  ro,
  output logic                  ci
);
  logic            pg_ok;
  logic [PA_W-1:0] set_mask;

  always_comb begin
    pg_ok  = pte[PG_VALID_BIT];
    ro     = seg_ro | pte[RO_BIT];
    ci     = pte[NOCACHE_BIT];
    frame  = pte[PA_W-1:OFF_W];

    flt            = '0;
    flt[FLT_PAGE]  = !pg_ok;
    flt[FLT_PROT]  = pg_ok && is_write && ro;

    set_mask            = '0;
    set_mask[USED_BIT]  = 1'b1;
    set_mask[DIRTY_BIT] = is_write;
    wb_val  = pte | set_mask;
    need_wb = (wb_val != pte);
  end
endmodule

// File: rtl/pw_walk_ctl.sv
`timescale 1ns/1ps
module pw_walk_ctl
  import pw_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32,
  localparam int VA_W  = 2 * IDX_W + OFF_W,
  localparam int FRM_W = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_super,
  input  logic              req_write,
  input  logic [PA_W-1:0]   seg_addr,
  input  logic [PA_W-1:0]   pte_addr,
  input  logic [FLT_W-1:0]  pte_flt,
  input  logic              pte_need_wb,
  input  logic [PA_W-1:0]   pte_wb_val,
  input  logic [FRM_W-1:0]  pte_frame,
  input  logic              pte_ro,
  input  logic              pte_ci,
  output logic [PA_W-1:0]   cur_pte,
  output logic [IDX_W-1:0]  seg_idx_o,
  output logic [IDX_W-1:0]  pg_idx_o,
  output logic              super_o,
  output logic [FRM_W-1:0]  seg_frame_o,
  output logic              seg_ro_o,
  output logic              write_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [PA_W-1:0]   mem_wdata,
  input  logic [PA_W-1:0]   mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic [PA_W-1:0]   out_pa,
  output logic              out_ro,
  output logic              out_ci,
  output logic [FLT_W-1:0]  fault
);
  walk_st_t         st_q;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  pte_q;

  assign busy      = (st_q != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st_q == ST_WB);
  assign mem_addr  = (st_q == ST_SEG) ? seg_addr : pte_addr;
  assign mem_wdata = pte_q;
  assign cur_pte   = (st_q == ST_WB) ? pte_q : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      off_q       <= '0;
      pte_q       <= '0;
      seg_idx_o   <= '0;
      pg_idx_o    <= '0;
      super_o     <= 1'b0;
      write_o     <= 1'b0;
      seg_frame_o <= '0;
      seg_ro_o    <= 1'b0;
      done        <= 1'b0;
      fault       <= '0;
      out_pa      <= '0;
      out_ro      <= 1'b0;
      out_ci      <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= '0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            seg_idx_o <= req_va[VA_W-1 -: IDX_W];
            pg_idx_o  <= req_va[OFF_W +: IDX_W];
            off_q     <= req_va[OFF_W-1:0];
            super_o   <= req_super;
            write_o   <= req_write;
            st_q      <= ST_SEG;
          end
        end
        ST_SEG: begin
          if (mem_ready) begin
            seg_frame_o <= mem_rdata[PA_W-1:OFF_W];
            seg_ro_o    <= mem_rdata[RO_BIT];
            if (!mem_rdata[SEG_VALID_BIT]) begin
              done             <= 1'b1;
              fault[FLT_TABLE] <= 1'b1;
              out_pa           <= '0;
              out_ro           <= 1'b0;
              out_ci           <= 1'b0;
              st_q             <= ST_IDLE;
            end else begin
              st_q <= ST_PTE;
            end
          end
        end
        ST_PTE: begin
          if (mem_ready) begin
            if (|pte_flt) begin
              done   <= 1'b1;
              fault  <= pte_flt;
              out_pa <= '0;
              out_ro <= 1'b0;
              out_ci <= 1'b0;
              st_q   <= ST_IDLE;
            end else if (pte_need_wb) begin
              pte_q <= pte_wb_val;
              st_q  <= ST_WB;
            end else begin
              done   <= 1'b1;
              out_pa <= {pte_frame, off_q};
              out_ro <= pte_ro;
              out_ci <= pte_ci;
              st_q   <= ST_IDLE;
            end
          end
        end
        default: begin
          if (mem_ready) begin
            done   <= 1'b1;
            out_pa <= {pte_frame, off_q};
            out_ro <= pte_ro;
            out_ci <= pte_ci;
            st_q   <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R8
  fault_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fault));
  // R8
  fault_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (|fault) |-> done);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3
  table_fault_src_chk: assert property (@(posedge clk) disable iff (rst)
    fault[FLT_TABLE] |-> $past(st_q == ST_SEG));
  // R7
  wb_used_set_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata[USED_BIT] && (mem_wdata[DIRTY_BIT] || !write_o)));
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!done && !busy && fault == '0));
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pw_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32,
  localparam int VA_W  = 2 * IDX_W + OFF_W,
  localparam int FRM_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_super,
  input  logic             req_write,
  input  logic [FRM_W-1:0] usr_base,
  input  logic [FRM_W-1:0] sup_base,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PA_W-1:0]  mem_wdata,
  input  logic [PA_W-1:0]  mem_rdata,
  input  logic             mem_ready,
  output logic             busy,
  output logic             done,
  output logic [PA_W-1:0]  out_pa,
  output logic             out_ro,
  output logic             out_ci,
  output logic [2:0]       fault
);
  logic [PA_W-1:0]  seg_addr, pte_addr, cur_pte, wb_val;
  logic [IDX_W-1:0] seg_idx, pg_idx;
  logic             super_q, seg_ro, write_q, need_wb, e_ro, e_ci;
  logic [FRM_W-1:0] seg_frame, e_frame, base_sel;
  logic [FLT_W-1:0] e_flt;

  assign base_sel = super_q ? sup_base : usr_base;

  pw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_seg_addr (
    .frame(base_sel), .idx(seg_idx), .addr(seg_addr));

  pw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_pte_addr (
    .frame(seg_frame), .idx(pg_idx), .addr(pte_addr));

  pw_pte_eval #(.OFF_W(OFF_W), .PA_W(PA_W)) u_eval (
    .pte(cur_pte), .seg_ro(seg_ro), .is_write(write_q),
    .flt(e_flt), .need_wb(need_wb), .wb_val(wb_val),
    .frame(e_frame), .ro(e_ro), .ci(e_ci));

  pw_walk_ctl #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_ctl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_va(req_va),
    .req_super(req_super), .req_write(req_write),
    .seg_addr(seg_addr), .pte_addr(pte_addr),
    .pte_flt(e_flt), .pte_need_wb(need_wb), .pte_wb_val(wb_val),
    .pte_frame(e_frame), .pte_ro(e_ro), .pte_ci(e_ci),
    .cur_pte(cur_pte), .seg_idx_o(seg_idx), .pg_idx_o(pg_idx),
    .super_o(super_q), .seg_frame_o(seg_frame), .seg_ro_o(seg_ro),
    .write_o(write_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .out_pa(out_pa),
    .out_ro(out_ro), .out_ci(out_ci), .fault(fault));

  // R5
  prot_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    fault[FLT_PROT] |-> write_q);
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 2;
  localparam int OFF_W = 12;
  localparam int PA_W  = 32;
  localparam int VA_W  = 2 * IDX_W + OFF_W;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_super = 1'b0, req_write = 1'b0;
  logic [VA_W-1:0] req_va = '0;
  logic [19:0] usr_base = 20'h00100, sup_base = 20'h00200;
  logic mem_req, mem_we, busy, done, out_ro, out_ci;
  logic [31:0] mem_addr, mem_wdata, out_pa;
  logic [31:0] mem_rdata = '0;
  logic mem_ready = 1'b0;
  logic [2:0] fault;

  int checks = 0, errors = 0, cycles = 0;
  int lat_cnt = 0, cur_lat = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd0 = '0, rd1 = '0, wr_addr = '0, wr_data = '0;
  bit [31:0] mem_a [bit [31:0]];

  pt_walker #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_super(req_super), .req_write(req_write),
    .usr_base(usr_base), .sup_base(sup_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .out_pa(out_pa), .out_ro(out_ro),
    .out_ci(out_ci), .fault(fault));

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model with a per-walk wait of cur_lat cycles per transfer
  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0;
      lat_cnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      lat_cnt = 0;
    end else if (mem_req) begin
      if (lat_cnt >= cur_lat) begin
        mem_ready = 1'b1;
        if (mem_we) begin
          mem_a[mem_addr] = mem_wdata;
          wr_addr = mem_addr;
          wr_data = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mem_a[mem_addr];
          if (rd_cnt == 0) rd0 = mem_addr; else rd1 = mem_addr;
          rd_cnt++;
        end
      end else begin
        lat_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic run_walk(input int k, input bit w, input bit m);
    logic [1:0] s, p;
    logic [11:0] off;
    logic [19:0] base, pt_frame, pg_frame;
    logic [31:0] seg_w, pte_w, seg_ad, pte_ad, exp_pa, exp_wb;
    logic sv, sro, pv, pro, ci, used, dirty, need;
    logic [2:0] exp_f;
    int n;
    s = 2'(k % 4); p = 2'((k / 4) % 4);
    off = 12'((k * 37) & 12'hfff);
    sv = k[0]; sro = k[1]; pv = k[2]; pro = k[3]; ci = k[4];
    used = k[5]; dirty = k[6];
    base = m ? sup_base : usr_base;
    pt_frame = 20'h00300 + 20'(m * 16) + 20'(s);
    pg_frame = 20'hA0000 ^ 20'(k * 3) ^ (20'(m) << 8);
    seg_w = {pt_frame, 8'h00, 1'b1, sro, sv, 1'b0};
    pte_w = {pg_frame, 5'((k * 5) & 31), ci, 1'b0, dirty, used, pro, 1'b0, pv};
    seg_ad = {base, 12'h000} | {28'h0, s, 2'b00};
    pte_ad = {pt_frame, 12'h000} | {28'h0, p, 2'b00};
    mem_a[seg_ad] = seg_w;
    mem_a[pte_ad] = pte_w;
    if (!sv) exp_f = 3'b001;
    else if (!pv) exp_f = 3'b010;
    else if (w && (sro || pro)) exp_f = 3'b100;
    else exp_f = 3'b000;
    need = (exp_f == 0) && (!used || (w && !dirty));
    exp_wb = pte_w | 32'h8 | (w ? 32'h10 : 32'h0);
    exp_pa = (exp_f == 0) ? {pg_frame, off} : 32'h0;
    rd_cnt = 0; wr_cnt = 0; cur_lat = k % 3;

    req_va = {s, p, off}; req_write = w; req_super = m; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R8 done seen", 32'(done), 32'h1);
    chk(fault == exp_f, exp_f == 3'b001 ? "R3 fault" :
        exp_f == 3'b010 ? "R4 fault" : "R5 fault", 32'(fault), 32'(exp_f));
    chk(out_pa == exp_pa, "R6 pa", out_pa, exp_pa);
    chk(out_ro == ((exp_f == 0) && (sro || pro)), "R6 ro", 32'(out_ro),
        32'((exp_f == 0) && (sro || pro)));
    chk(out_ci == ((exp_f == 0) && ci), "R6 ci", 32'(out_ci),
        32'((exp_f == 0) && ci));
    chk(rd0 == seg_ad, "R1 segment address", rd0, seg_ad);
    chk(rd_cnt == (sv ? 2 : 1), "R3 read count", 32'(rd_cnt), sv ? 32'd2 : 32'd1);
    if (sv) chk(rd1 == pte_ad, "R2 page address", rd1, pte_ad);
    chk(wr_cnt == (need ? 1 : 0), "R7 write count", 32'(wr_cnt), need ? 32'd1 : 32'd0);
    if (need) begin
      chk(wr_addr == pte_ad, "R7 write address", wr_addr, pte_ad);
      chk(wr_data == exp_wb, "R7 write data", wr_data, exp_wb);
    end else begin
      chk(mem_a[pte_ad] == pte_w, "R7 entry unchanged", mem_a[pte_ad], pte_w);
    end
    @(negedge clk);
    chk(!done && fault == 3'b000, "R8 done pulse", {28'h0, done, fault}, 32'h0);
  endtask

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog act %0d exp <%0d", cycles, WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 state during reset
    chk(!done && fault == 0 && !mem_req && !busy, "R10 in reset",
        {27'h0, done, fault, busy}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    // R10 state after reset
    chk(!done && fault == 0 && !mem_req && !busy, "R10 after reset",
        {27'h0, done, fault, busy}, 32'h0);
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 128; k++)
          run_walk(k, w[0], m[0]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule